// File: doc/BRIEF.md
# Masked Configuration Register File

This block holds a 256-byte configuration space for a bus endpoint. A single access port reads or writes it. A read returns 1, 2 or 4 bytes from any byte offset, assembled little-endian and zero-extended to 32 bits. A write goes through a fixed per-byte write mask. Read-only bits and bytes therefore keep their reset values, while writable bits take the new data.

Identification, class and header bytes are read-only and come from parameters. The command byte exposes three writable enable bits: I/O, memory and bus master. The six 32-bit address registers have writable bits set by a parameter. The cache-line byte, the interrupt-line byte and the whole upper region are fully writable. Beside the data path the block raises a one-cycle `remap_pulse` after any write that changes address decoding. Logic outside the block uses it to recompute address windows.

Top module: `cfg_space_regfile`

## Requirements
- R1: After reset, a 4-byte read at 0x00 returns {DEVICE_ID, VENDOR_ID}. Byte 0x08 holds REVISION and bytes 0x09..0x0B hold CLASS_CODE (low byte first). Byte 0x0E holds HEADER_KIND, and bytes 0x10..0x27 hold BAR_RESET (BAR0 first, little-endian). Every other byte holds 0.
- R2: A write of length n (1, 2 or 4) updates bytes addr..addr+n-1. Byte addr+k takes data bits [8k+7:8k] and becomes (old AND NOT mask) OR (data AND mask). The update is visible to reads from the cycle after the write.
- R3: Byte 0x04 has write mask 0x07: bit 0 is I/O enable, bit 1 is memory enable and bit 2 is bus-master enable. Byte 0x05 has mask 0x00.
- R4: Bytes 0x00..0x03, 0x05..0x0B, 0x0D..0x0F and 0x28..0x3B have a zero mask. Writes to them leave them unchanged.
- R5: Bytes 0x0C, 0x3C and 0x40..0xFF have mask 0xFF.
- R6: Address register k spans bytes 0x10+4k..0x13+4k, and its write mask is BAR_WMASK[32k+31:32k]. The defaults are 0xFFFFFFF0 for k=0, 0xFFFFFF00 for k=1 and 0 for the rest.
- R7: acc_len=1 is valid at any offset, acc_len=2 only at offsets up to 0xFE, and acc_len=4 only at offsets up to 0xFC. An invalid read, including any other acc_len value, returns 0xFFFFFFFF.
- R8: A write that runs past 0xFF stops at 0xFF and does not wrap to 0x00.
- R9: remap_pulse is high for exactly the cycle after a write that changes any byte in 0x10..0x27 or changes bit 0 or bit 1 of byte 0x04. Otherwise it is low, including for writes that only toggle bus master or rewrite the same value.
- R10: A write with acc_len other than 1, 2 or 4 changes no byte and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_we | input | 1 | Write strobe for this cycle |
| acc_addr | input | 8 | Byte offset of the access |
| acc_len | input | 3 | Access length in bytes (1, 2 or 4) |
| acc_wdata | input | 32 | Write data, lowest byte to lowest offset |
| acc_rdata | output | 32 | Read data for acc_addr/acc_len from current contents |
| remap_pulse | output | 1 | One-cycle pulse after a decode-affecting write |

## Verification
The strobe for one write and the data update of the next write land in the same cycle whenever writes come back to back. In that case the pulse shown for the first write must not be stretched, cleared or merged by the second. The random stream issues consecutive writes to the command byte and the address registers, often at the same offsets. After each edge the bench compares the pulse against a model that recomputes the change test for that single write only. The read data in the pulse cycle is also compared, to confirm it already reflects the write that raised the pulse.

// File: rtl/cfg_space_regfile.sv
module cfg_space_regfile #(
  parameter logic [15:0]  VENDOR_ID   = 16'hC0DE,
  parameter logic [15:0]  DEVICE_ID   = 16'h0A17,
  parameter logic [7:0]   REVISION    = 8'h02,
  parameter logic [23:0]  CLASS_CODE  = 24'h028000,
  parameter logic [7:0]   HEADER_KIND = 8'h00,
  parameter logic [191:0] BAR_WMASK   = {128'h0, 32'hFFFFFF00, 32'hFFFFFFF0},
  parameter logic [191:0] BAR_RESET   = {160'h0, 32'h00000001}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_we,
  input  logic [7:0]  acc_addr,
  input  logic [2:0]  acc_len,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        remap_pulse
);
  localparam int SPACE   = 256;
  localparam int BAR_LO  = 16;
  localparam int BAR_HI  = BAR_LO + 24;
  localparam int CMD_OFS = 4;

  function automatic logic [7:0] wmask_of(int unsigned a);
    if (a >= 64)                  return 8'hFF;
    if (a == 12 || a == 60)       return 8'hFF;
    if (a == CMD_OFS)             return 8'h07;
    if (a >= BAR_LO && a < BAR_HI) return BAR_WMASK[(a - BAR_LO)*8 +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] init_of(int unsigned a);
    case (a)
      0:  return VENDOR_ID[7:0];
      1:  return VENDOR_ID[15:8];
      2:  return DEVICE_ID[7:0];
      3:  return DEVICE_ID[15:8];
      8:  return REVISION;
      9:  return CLASS_CODE[7:0];
      10: return CLASS_CODE[15:8];
      11: return CLASS_CODE[23:16];
      14: return HEADER_KIND;
      default: begin
        if (a >= BAR_LO && a < BAR_HI) return BAR_RESET[(a - BAR_LO)*8 +: 8];
        return 8'h00;
      end
    endcase
  endfunction

  logic [7:0] regs [SPACE];
  logic [7:0] nxt  [SPACE];
  logic       len_ok;
  logic       bar_chg, cmd_chg;

  assign len_ok = (acc_len == 3'd1) || (acc_len == 3'd2) || (acc_len == 3'd4);

  for (genvar g = 0; g < SPACE; g++) begin : g_byte
    localparam logic [7:0] M = wmask_of(g);
    wire [8:0] off = 9'(g) - {1'b0, acc_addr};
    wire       hit = acc_we && len_ok && (off < {6'd0, acc_len});
    wire [7:0] din = acc_wdata[off[1:0]*8 +: 8];
    assign nxt[g] = hit ? ((regs[g] & ~M) | (din & M)) : regs[g];
  end

  always_comb begin
    bar_chg = 1'b0;
    for (int i = BAR_LO; i < BAR_HI; i++)
      if (nxt[i] != regs[i]) bar_chg = 1'b1;
    cmd_chg = (nxt[CMD_OFS][1:0] != regs[CMD_OFS][1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SPACE; i++) regs[i] <= init_of(i);
      remap_pulse <= 1'b0;
    end else begin
      for (int i = 0; i < SPACE; i++) regs[i] <= nxt[i];
      remap_pulse <= bar_chg | cmd_chg;
    end
  end

  always_comb begin
    acc_rdata = '1;
    case (acc_len)
      3'd1: acc_rdata = {24'h0, regs[acc_addr]};
      3'd2: if (acc_addr <= 8'hFE)
              acc_rdata = {16'h0, regs[acc_addr + 8'd1], regs[acc_addr]};
      3'd4: if (acc_addr <= 8'hFC)
              acc_rdata = {regs[acc_addr + 8'd3], regs[acc_addr + 8'd2],
                           regs[acc_addr + 8'd1], regs[acc_addr]};
      default: acc_rdata = '1;
    endcase
  end

  assert_pulse_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    remap_pulse |-> $past(acc_we));

  assert_no_pulse_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> !remap_pulse);

  assert_bad_len_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we && !len_ok) |=> !remap_pulse);

  assert_cmd_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    regs[CMD_OFS][7:3] == 5'd0);

  assert_vendor_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 $stable(regs[0]) && $stable(regs[2]));

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(regs[CMD_OFS]));
endmodule

// File: tb/cfg_space_regfile_bench.sv
module cfg_space_regfile_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_we = 0;
  logic [7:0]  acc_addr = 0;
  logic [2:0]  acc_len = 3'd1;
  logic [31:0] acc_wdata = 0;
  logic [31:0] acc_rdata;
  logic        remap_pulse;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] mdl [256];

  always #2 clk = ~clk;

  cfg_space_regfile u_cfg_space_regfile (
    .clk(clk), .rst_n(rst_n), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_len(acc_len), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .remap_pulse(remap_pulse));

  function automatic logic [7:0] bmask(int a);
    if (a == 4) return 8'h07;
    if (a == 12 || a == 60 || a > 63) return 8'hFF;
    if (a >= 16 && a <= 18) return 8'hFF;
    if (a == 19) return 8'hFF;
    if (a == 16) return 8'hF0;
    if (a >= 21 && a <= 23) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [7:0] mask_of(int a);
    if (a == 16) return 8'hF0;
    if (a == 20) return 8'h00;
    return bmask(a);
  endfunction

  function automatic logic [7:0] binit(int a);
    case (a)
      0: return 8'hDE; 1: return 8'hC0; 2: return 8'h17; 3: return 8'h0A;
      8: return 8'h02; 9: return 8'h00; 10: return 8'h80; 11: return 8'h02;
      16: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] mread(int a, int n);
    if (n == 1) return {24'h0, mdl[a]};
    if (n == 2 && a <= 254) return {16'h0, mdl[a+1], mdl[a]};
    if (n == 4 && a <= 252) return {mdl[a+3], mdl[a+2], mdl[a+1], mdl[a]};
    return 32'hFFFFFFFF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(bit we, int a, int n, logic [31:0] d, string req);
    logic [7:0] nw [256];
    bit pexp;
    @(negedge clk);
    acc_we = we; acc_addr = 8'(a); acc_len = 3'(n); acc_wdata = d;
    #1;
    chk({req, " R7 read"}, acc_rdata, mread(a, n));
    nw = mdl;
    if (we && (n == 1 || n == 2 || n == 4))
      for (int k = 0; k < n; k++)
        if (a + k < 256) begin
          logic [7:0] mk = mask_of(a + k);
          nw[a+k] = (mdl[a+k] & ~mk) | (d[8*k +: 8] & mk);
        end
    pexp = (nw[4][1:0] != mdl[4][1:0]);
    for (int i = 16; i < 40; i++) if (nw[i] != mdl[i]) pexp = 1;
    @(posedge clk); #1;
    mdl = nw;
    chk({req, " R9 pulse"}, {31'h0, remap_pulse}, {31'h0, pexp});
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mdl[i] = binit(i);
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    op(0, 0, 4, 0, "R1 ids");
    chk("R1 ids value", acc_rdata, 32'h0A17C0DE);
    op(0, 8, 4, 0, "R1 class");
    op(0, 16, 4, 0, "R1 bar0");
    chk("R1 bar0 value", acc_rdata, 32'h00000001);
    op(1, 4, 2, 32'hFFFF, "R3 cmd all");
    op(0, 4, 2, 0, "R3 cmd read");
    chk("R3 cmd mask", acc_rdata, 32'h00000007);
    op(1, 4, 1, 32'h03, "R9 master only");
    op(1, 4, 1, 32'h00, "R9 io mem flip");
    op(1, 0, 4, 32'h12345678, "R4 id write");
    op(0, 0, 4, 0, "R4 id read");
    chk("R4 id held", acc_rdata, 32'h0A17C0DE);
    op(1, 16, 4, 32'hFFFFFFFF, "R6 bar0");
    op(1, 16, 4, 32'hFFFFFFFF, "R6 bar0 same");
    op(0, 16, 4, 0, "R6 bar0 read");
    chk("R6 bar0 value", acc_rdata, 32'hFFFFFFF1);
    op(1, 20, 4, 32'h89ABCDEF, "R6 bar1");
    op(1, 24, 4, 32'hFFFFFFFF, "R6 bar2 ro");
    op(1, 12, 1, 32'hA5, "R5 cls");
    op(1, 60, 2, 32'h5A3C, "R5 intline");
    op(1, 128, 4, 32'hDEADBEEF, "R5 upper");
    op(1, 254, 4, 32'hAABBCCDD, "R8 cross");
    op(0, 254, 2, 0, "R8 tail");
    chk("R8 tail value", acc_rdata, 32'h0000CCDD);
    op(0, 0, 1, 0, "R8 no wrap");
    chk("R8 no wrap value", acc_rdata, 32'h000000DE);
    op(0, 253, 4, 0, "R7 oob4");
    op(0, 255, 2, 0, "R7 oob2");
    op(0, 64, 3, 0, "R7 badlen");
    op(1, 64, 3, 32'h11223344, "R10 badlen write");
    op(1, 4, 0, 32'hFF, "R10 zero len");
    op(0, 64, 4, 0, "R10 read");
    chk("R10 unchanged", acc_rdata, 32'h0);

    for (int t = 0; t < 4000; t++) begin
      int a, n, sel;
      sel = $urandom % 8;
      n = (sel < 3) ? 1 : (sel < 5) ? 2 : (sel < 7) ? 4 : ($urandom % 8);
      a = ($urandom % 2) ? ($urandom % 256) : ($urandom % 48);
      op(($urandom % 3) != 0, a, n, $urandom, "R2 random");
    end
    @(negedge clk); acc_we = 0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule